// File: doc/BRIEF.md
# Instruction Prefix and Operating-Size Resolver

This block sits at the front of an x86 instruction decoder. It takes the bytes of one instruction, one byte per clock, and sorts each byte into one of three kinds: a legacy prefix, a register-extension (REX) prefix, or the first opcode byte. Legacy prefixes are the lock/repeat group, the six segment overrides, the operand-size override and the address-size override. When the opcode byte arrives, the block ends the scan. On the next cycle it presents a result set: the opcode byte, the effective operand and address sizes for the selected decoding mode (16, 32 or 64 bit), the segment override that survives, the lock/repeat byte, whether a byte qualifies as a candidate mandatory SSE prefix, and the REX W/R/X/B bits together with a flag that shows a REX prefix took effect.

The upstream fetch unit marks the first byte of each instruction with `firstIn`. A marked byte always starts a fresh scan. Unmarked bytes count only while a scan is open. The result stays on the outputs, with `prefixDone` high, until the next marked byte arrives. Mode codes and size codes use the same encoding: 0 means 16-bit, 1 means 32-bit and 2 means 64-bit. A mode code of 3 behaves as 32-bit. Opcode legality and lock legality are left to later stages. A byte flagged as a mandatory candidate still acts as a normal prefix in the size results.

Top module: `pfxres_top`

## Requirements
- R1: After reset `prefixDone` is 0. A byte with `byteValid` and `firstIn` both high starts a new scan and clears `prefixDone` on the following cycle.
- R2: The first accepted byte that is neither a legacy prefix nor an honoured REX byte ends the scan. `prefixDone` rises the cycle after that byte is accepted, and `opcodeOut` holds that byte. Bytes that arrive without `firstIn` while `prefixDone` is high have no effect on any output.
- R3: In 16-bit mode the operand size is 16, or 32 when byte 66 is present. In 32-bit mode it is 32, or 16 when 66 is present.
- R4: In 16-bit mode the address size is 16, or 32 with byte 67. In 32-bit mode it is 32, or 16 with 67. In 64-bit mode it is 64, or 32 with 67.
- R5: In 64-bit mode the operand size is 64 when the honoured REX has W (bit 3) set, and 66 is then ignored. Otherwise it is 32, or 16 when 66 is present.
- R6: Bytes 40..4F are REX prefixes only in 64-bit mode. In other modes they end the scan as opcodes. A REX byte takes effect only when the next byte is the opcode: a later legacy prefix discards it, and a later REX replaces it. The honoured REX drives `rexW`, `rexR`, `rexX` and `rexB` from bits 3, 2, 1 and 0, and sets `rexSeen` even when its value is 40. With no honoured REX, all five outputs are 0.
- R7: The lock/repeat group (F0, F2, F3) keeps the last byte seen. `lockRepOut` reports it as 0 for none, 1 for F0, 2 for F2 and 3 for F3.
- R8: `segOut` reports the last effective segment override as 0 for none, 1 for 26, 2 for 2E, 3 for 36, 4 for 3E, 5 for 64 and 6 for 65. In 64-bit mode, bytes 26, 2E, 36 and 3E still count as prefixes but change nothing in `segOut`.
- R9: `mandOut` is 1, 2 or 3 when the last legacy prefix before the opcode, or before the REX that precedes it, is 66, F2 or F3 respectively. Otherwise `mandOut` is 0.
- R10: `errOut` is 1 when the instruction carries more than four legacy prefix bytes, repeats included. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A byte is present on `byteIn` this cycle |
| firstIn | input | 1 | The present byte is the first byte of an instruction |
| byteIn | input | 8 | Instruction stream byte |
| modeIn | input | 2 | Decoding mode: 0 = 16-bit, 1 = 32-bit, 2 = 64-bit |
| prefixDone | output | 1 | Scan finished; the result outputs are valid |
| opcodeOut | output | 8 | First opcode byte |
| opSizeOut | output | 2 | Effective operand size code |
| adrSizeOut | output | 2 | Effective address size code |
| segOut | output | 3 | Surviving segment override code |
| lockRepOut | output | 2 | Lock/repeat group code |
| mandOut | output | 2 | Candidate mandatory prefix code |
| rexSeen | output | 1 | An honoured REX prefix preceded the opcode |
| rexW | output | 1 | REX W bit |
| rexR | output | 1 | REX R bit |
| rexX | output | 1 | REX X bit |
| rexB | output | 1 | REX B bit |
| errOut | output | 1 | More than four legacy prefixes |

## Verification
All internal state builds up while the prefixes stream in. None of it reaches the ports until the cycle after the opcode byte. Any stale or wrong accumulator value therefore shows up as a wrong size, code or REX bit exactly one cycle after that byte. The most telling sequences are those where a REX byte precedes a legacy prefix, where the same group repeats, where 64-bit mode meets an ineffective segment override, and where an instruction carries five or more prefixes. An open-scan flag that was not cleared would show up as outputs that change after `prefixDone`, which is why stray bytes are sent after each result.

// File: rtl/pfxres_pkg.sv
package pfxres_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ32 = 2'd1,
    SZ64 = 2'd2
  } size_e;

  // Strobes from the classifier to the accumulating datapath
  typedef struct packed {
    logic start;     // restart accumulation with this byte
    logic legacy;    // byte is a legacy prefix
    logic lockLoad;  // lock/repeat group byte
    logic segLoad;   // effective segment override
    logic opOvr;     // operand-size override
    logic adrOvr;    // address-size override
    logic rexLoad;   // REX byte (64-bit mode)
    logic finish;    // byte is the opcode
  } strobe_t;

endpackage

// File: rtl/pfxres_ctrl.sv
module pfxres_ctrl
  import pfxres_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              firstIn,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic [1:0]        modeIn,
  output strobe_t           strobe
);

  logic scanQ;
  logic accept;
  logic isLockRep, isSeg, isOldSeg, isOp, isAdr, isRex, isLegacy, mode64;

  always_comb begin
    mode64    = (modeIn == SZ64);
    isLockRep = (byteIn == 8'hF0) || (byteIn == 8'hF2) || (byteIn == 8'hF3);
    isOldSeg  = (byteIn == 8'h26) || (byteIn == 8'h2E) ||
                (byteIn == 8'h36) || (byteIn == 8'h3E);
    isSeg     = isOldSeg || (byteIn == 8'h64) || (byteIn == 8'h65);
    isOp      = (byteIn == 8'h66);
    isAdr     = (byteIn == 8'h67);
    isRex     = mode64 && (byteIn[7:4] == 4'h4);
    isLegacy  = isLockRep || isSeg || isOp || isAdr;
    accept    = byteValid && (firstIn || scanQ);

    strobe.start    = byteValid && firstIn;
    strobe.legacy   = accept && isLegacy;
    strobe.lockLoad = accept && isLockRep;
    strobe.segLoad  = accept && isSeg && !(mode64 && isOldSeg);
    strobe.opOvr    = accept && isOp;
    strobe.adrOvr   = accept && isAdr;
    strobe.rexLoad  = accept && isRex;
    strobe.finish   = accept && !isLegacy && !isRex;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       scanQ <= 1'b0;
    else if (accept) scanQ <= !strobe.finish;
  end

endmodule

// File: rtl/pfxres_dp.sv
module pfxres_dp
  import pfxres_pkg::*;
#(
  parameter int MAX_LEGACY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic [1:0]        modeIn,
  output logic              prefixDone,
  output logic [BYTE_W-1:0] opcodeOut,
  output logic [1:0]        opSizeOut,
  output logic [1:0]        adrSizeOut,
  output logic [2:0]        segOut,
  output logic [1:0]        lockRepOut,
  output logic [1:0]        mandOut,
  output logic              rexSeen,
  output logic [3:0]        rexBits,
  output logic              errOut
);

  localparam int CNT_MAX = MAX_LEGACY + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  // accumulators
  logic [1:0]       lockQ, lockN, lockB;
  logic [2:0]       segQ, segN, segB;
  logic             opQ, opN, opB;
  logic             adQ, adN, adB;
  logic [1:0]       lastQ, lastN, lastB;
  logic [CNT_W-1:0] cntQ, cntN, cntB;
  logic             rexVQ, rexVN, rexVB;
  logic [3:0]       rexQ, rexN, rexB4;
  logic [1:0]       opSz, adSz;
  logic [2:0]       segCode;
  logic [1:0]       lockCode, lastCode;

  always_comb begin
    case (byteIn)
      8'h26:   segCode = 3'd1;
      8'h2E:   segCode = 3'd2;
      8'h36:   segCode = 3'd3;
      8'h3E:   segCode = 3'd4;
      8'h64:   segCode = 3'd5;
      8'h65:   segCode = 3'd6;
      default: segCode = 3'd0;
    endcase
    case (byteIn)
      8'hF0:   lockCode = 2'd1;
      8'hF2:   lockCode = 2'd2;
      8'hF3:   lockCode = 2'd3;
      default: lockCode = 2'd0;
    endcase
    case (byteIn)
      8'h66:   lastCode = 2'd1;
      8'hF2:   lastCode = 2'd2;
      8'hF3:   lastCode = 2'd3;
      default: lastCode = 2'd0;
    endcase
  end

  always_comb begin
    // a first byte starts from a cleared set
    lockB = strobe.start ? '0 : lockQ;
    segB  = strobe.start ? '0 : segQ;
    opB   = strobe.start ? '0 : opQ;
    adB   = strobe.start ? '0 : adQ;
    lastB = strobe.start ? '0 : lastQ;
    cntB  = strobe.start ? '0 : cntQ;
    rexVB = strobe.start ? '0 : rexVQ;
    rexB4 = strobe.start ? '0 : rexQ;

    lockN = strobe.lockLoad ? lockCode : lockB;
    segN  = strobe.segLoad  ? segCode  : segB;
    opN   = opB | strobe.opOvr;
    adN   = adB | strobe.adrOvr;
    lastN = strobe.legacy ? lastCode : lastB;
    cntN  = (strobe.legacy && cntB != CNT_W'(CNT_MAX)) ? cntB + 1'b1 : cntB;
    rexVN = strobe.rexLoad ? 1'b1 : (strobe.legacy ? 1'b0 : rexVB);
    rexN  = strobe.rexLoad ? byteIn[3:0] : rexB4;

    case (modeIn)
      SZ16: begin
        opSz = opN ? SZ32 : SZ16;
        adSz = adN ? SZ32 : SZ16;
      end
      SZ64: begin
        opSz = (rexVN && rexN[3]) ? SZ64 : (opN ? SZ16 : SZ32);
        adSz = adN ? SZ32 : SZ64;
      end
      default: begin
        opSz = opN ? SZ16 : SZ32;
        adSz = adN ? SZ16 : SZ32;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ <= '0; segQ <= '0; opQ <= 1'b0; adQ <= 1'b0;
      lastQ <= '0; cntQ <= '0; rexVQ <= 1'b0; rexQ <= '0;
      prefixDone <= 1'b0; opcodeOut <= '0; opSizeOut <= '0;
      adrSizeOut <= '0; segOut <= '0; lockRepOut <= '0; mandOut <= '0;
      rexSeen <= 1'b0; rexBits <= '0; errOut <= 1'b0;
    end else begin
      lockQ <= lockN; segQ <= segN; opQ <= opN; adQ <= adN;
      lastQ <= lastN; cntQ <= cntN; rexVQ <= rexVN; rexQ <= rexN;
      if (strobe.finish) begin
        prefixDone <= 1'b1;
        opcodeOut  <= byteIn;
        opSizeOut  <= opSz;
        adrSizeOut <= adSz;
        segOut     <= segN;
        lockRepOut <= lockN;
        mandOut    <= lastN;
        rexSeen    <= rexVN;
        rexBits    <= rexVN ? rexN : 4'h0;
        errOut     <= (cntN > CNT_W'(MAX_LEGACY));
      end else if (strobe.start) begin
        prefixDone <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pfxres_top.sv
module pfxres_top
  import pfxres_pkg::*;
#(
  parameter int MAX_LEGACY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       firstIn,
  input  logic [7:0] byteIn,
  input  logic [1:0] modeIn,
  output logic       prefixDone,
  output logic [7:0] opcodeOut,
  output logic [1:0] opSizeOut,
  output logic [1:0] adrSizeOut,
  output logic [2:0] segOut,
  output logic [1:0] lockRepOut,
  output logic [1:0] mandOut,
  output logic       rexSeen,
  output logic       rexW,
  output logic       rexR,
  output logic       rexX,
  output logic       rexB,
  output logic       errOut
);

  strobe_t    strobe;
  logic [3:0] rexBits;

  pfxres_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .firstIn(firstIn),
    .byteIn(byteIn), .modeIn(modeIn), .strobe(strobe)
  );

  pfxres_dp #(.MAX_LEGACY(MAX_LEGACY)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIn(byteIn), .modeIn(modeIn),
    .prefixDone(prefixDone), .opcodeOut(opcodeOut), .opSizeOut(opSizeOut),
    .adrSizeOut(adrSizeOut), .segOut(segOut), .lockRepOut(lockRepOut),
    .mandOut(mandOut), .rexSeen(rexSeen), .rexBits(rexBits), .errOut(errOut)
  );

  assign rexW = rexBits[3];
  assign rexR = rexBits[2];
  assign rexX = rexBits[1];
  assign rexB = rexBits[0];

endmodule

// File: rtl/pfxres_chk.sv
module pfxres_chk (
  input logic       clk,
  input logic       rstN,
  input logic       byteValid,
  input logic       firstIn,
  input logic [7:0] byteIn,
  input logic [1:0] modeIn,
  input logic       prefixDone,
  input logic [7:0] opcodeOut,
  input logic [1:0] opSizeOut,
  input logic [1:0] adrSizeOut,
  input logic [2:0] segOut,
  input logic       rexSeen,
  input logic       rexW,
  input logic       rexR,
  input logic       rexX,
  input logic       rexB
);

  // R2: completion follows an accepted byte
  assert_done_after_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(prefixDone) |-> $past(byteValid));

  // R2: results hold until a new first byte
  assert_hold_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    (prefixDone && !(byteValid && firstIn)) |=> (prefixDone && $stable(opcodeOut)
      && $stable(opSizeOut) && $stable(segOut)));

  // R1: a first byte drops the done flag
  assert_restart_R1: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && firstIn && prefixDone) |=> (!prefixDone || $past(byteIn) == opcodeOut));

  // R6: outside 64-bit mode no REX and no 64-bit size
  assert_no_rex_legacy_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(prefixDone) && $past(modeIn) != 2'd2) |->
      (!rexSeen && opSizeOut != 2'd2 && adrSizeOut != 2'd2));

  // R4: 64-bit mode never reports a 16-bit address size
  assert_adr64_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(prefixDone) && $past(modeIn) == 2'd2) |-> (adrSizeOut != 2'd0));

  // R8: only FS/GS style overrides survive in 64-bit mode
  assert_seg64_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(prefixDone) && $past(modeIn) == 2'd2) |->
      (segOut == 3'd0 || segOut == 3'd5 || segOut == 3'd6));

  // R6: REX bits are zero without an honoured REX
  assert_rex_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (prefixDone && !rexSeen) |-> !(rexW || rexR || rexX || rexB));

  // R2: reported opcode is never a legacy prefix byte
  assert_opcode_not_prefix_R2: assert property (@(posedge clk) disable iff (!rstN)
    prefixDone |-> !(opcodeOut inside {8'hF0, 8'hF2, 8'hF3, 8'h66, 8'h67,
                                       8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65}));

endmodule

bind pfxres_top pfxres_chk u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .firstIn(firstIn),
  .byteIn(byteIn), .modeIn(modeIn), .prefixDone(prefixDone),
  .opcodeOut(opcodeOut), .opSizeOut(opSizeOut), .adrSizeOut(adrSizeOut),
  .segOut(segOut), .rexSeen(rexSeen), .rexW(rexW), .rexR(rexR),
  .rexX(rexX), .rexB(rexB)
);

// File: tb/pfxres_top_tb.sv
`timescale 1ns/1ps
module pfxres_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic       firstIn = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic [1:0] modeIn = 2'd0;
  logic       prefixDone;
  logic [7:0] opcodeOut;
  logic [1:0] opSizeOut, adrSizeOut, lockRepOut, mandOut;
  logic [2:0] segOut;
  logic       rexSeen, rexW, rexR, rexX, rexB, errOut;

  int testCount = 0;
  int failCount = 0;
  int cycles    = 0;
  logic [7:0] seq [16];
  int seqLen;

  always #2.5 clk = ~clk;

  pfxres_top u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .firstIn(firstIn),
    .byteIn(byteIn), .modeIn(modeIn), .prefixDone(prefixDone),
    .opcodeOut(opcodeOut), .opSizeOut(opSizeOut), .adrSizeOut(adrSizeOut),
    .segOut(segOut), .lockRepOut(lockRepOut), .mandOut(mandOut),
    .rexSeen(rexSeen), .rexW(rexW), .rexR(rexR), .rexX(rexX), .rexB(rexB),
    .errOut(errOut)
  );

  typedef struct packed {
    logic [7:0] opc;
    logic [1:0] op;
    logic [1:0] ad;
    logic [1:0] lock;
    logic [2:0] seg;
    logic [1:0] mand;
    logic       rexV;
    logic [3:0] rex;
    logic       err;
  } exp_t;

  function automatic bit isLegacyByte(input logic [7:0] b);
    return b inside {8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36, 8'h3E,
                     8'h64, 8'h65, 8'h66, 8'h67};
  endfunction

  // Expected result from the requirements
  function automatic exp_t model(input logic [1:0] m);
    exp_t e;
    bit opv = 0, adv = 0, rv = 0;
    logic [3:0] rx = 0;
    int cnt = 0;
    e = '0;
    for (int i = 0; i < seqLen; i++) begin
      logic [7:0] b = seq[i];
      if (isLegacyByte(b)) begin
        cnt++;
        rv = 0;
        e.mand = (b == 8'h66) ? 2'd1 : (b == 8'hF2) ? 2'd2 : (b == 8'hF3) ? 2'd3 : 2'd0;
        if (b == 8'hF0) e.lock = 1;
        if (b == 8'hF2) e.lock = 2;
        if (b == 8'hF3) e.lock = 3;
        if (b == 8'h66) opv = 1;
        if (b == 8'h67) adv = 1;
        if (b == 8'h64) e.seg = 5;
        if (b == 8'h65) e.seg = 6;
        if (m != 2'd2) begin
          if (b == 8'h26) e.seg = 1;
          if (b == 8'h2E) e.seg = 2;
          if (b == 8'h36) e.seg = 3;
          if (b == 8'h3E) e.seg = 4;
        end
      end else if (m == 2'd2 && b[7:4] == 4'h4) begin
        rv = 1;
        rx = b[3:0];
      end else begin
        e.opc = b;
        break;
      end
    end
    e.rexV = rv;
    e.rex  = rv ? rx : 4'h0;
    e.err  = (cnt > 4);
    if (m == 2'd0) begin
      e.op = opv ? 2'd1 : 2'd0; e.ad = adv ? 2'd1 : 2'd0;
    end else if (m == 2'd2) begin
      e.op = (rv && rx[3]) ? 2'd2 : (opv ? 2'd0 : 2'd1);
      e.ad = adv ? 2'd1 : 2'd2;
    end else begin
      e.op = opv ? 2'd0 : 2'd1; e.ad = adv ? 2'd0 : 2'd1;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic runInstr(input logic [1:0] m);
    exp_t e;
    modeIn = m;
    for (int i = 0; i < seqLen; i++) begin
      @(negedge clk);
      byteValid = 1'b1; firstIn = (i == 0); byteIn = seq[i];
    end
    @(negedge clk);
    byteValid = 1'b0; firstIn = 1'b0;
    e = model(m);
    chk("R2 done", int'(prefixDone), 1);
    chk("R2 opcode", int'(opcodeOut), int'(e.opc));
    chk(m == 2'd2 ? "R5 opsize" : "R3 opsize", int'(opSizeOut), int'(e.op));
    chk("R4 adrsize", int'(adrSizeOut), int'(e.ad));
    chk("R6 rex", int'({rexSeen, rexW, rexR, rexX, rexB}), int'({e.rexV, e.rex}));
    chk("R7 lockrep", int'(lockRepOut), int'(e.lock));
    chk("R8 segment", int'(segOut), int'(e.seg));
    chk("R9 mandatory", int'(mandOut), int'(e.mand));
    chk("R10 error", int'(errOut), int'(e.err));
  endtask

  task automatic set3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    seq[0] = a; seq[1] = b; seq[2] = c; seqLen = 3;
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    failCount++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : main
    logic [7:0] savedOp;
    logic [1:0] m;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset done", int'(prefixDone), 0);

    // directed corner cases
    seq[0] = 8'h66; seq[1] = 8'hAD; seqLen = 2; runInstr(2'd0);   // R3 16->32
    seq[0] = 8'h67; seq[1] = 8'h8B; seqLen = 2; runInstr(2'd1);   // R4 32->16
    set3(8'h48, 8'h66, 8'h89); runInstr(2'd2);                    // R6 REX dropped
    set3(8'h66, 8'h48, 8'h89); runInstr(2'd2);                    // R5 W wins, R9
    seq[0] = 8'h40; seq[1] = 8'h88; seqLen = 2; runInstr(2'd2);   // R6 bare REX
    seq[0] = 8'h41; seqLen = 1; runInstr(2'd1);                   // R6 opcode in 32
    set3(8'h64, 8'h3E, 8'h8B); runInstr(2'd2);                    // R8 FS survives
    set3(8'hF0, 8'hF3, 8'hA4); runInstr(2'd1);                    // R7 last wins
    set3(8'h45, 8'h4C, 8'h01); runInstr(2'd2);                    // R6 last REX
    seq[0] = 8'h26; seq[1] = 8'h2E; seq[2] = 8'h66; seq[3] = 8'h67;
    seq[4] = 8'hF2; seq[5] = 8'h0F; seqLen = 6; runInstr(2'd0);   // R10 five prefixes
    seq[0] = 8'h26; seq[1] = 8'h2E; seq[2] = 8'h66; seq[3] = 8'hF3;
    seq[4] = 8'h0F; seqLen = 5; runInstr(2'd1);                   // R10 exactly four

    // R2: stray bytes after completion change nothing
    savedOp = opcodeOut;
    @(negedge clk); byteValid = 1'b1; firstIn = 1'b0; byteIn = 8'h90;
    @(negedge clk); byteIn = 8'h66;
    @(negedge clk); byteValid = 1'b0;
    chk("R2 ignore opcode", int'(opcodeOut), int'(savedOp));
    chk("R2 ignore done", int'(prefixDone), 1);
    chk("R2 ignore mand", int'(mandOut), 3);

    // R1: a new first byte clears done
    @(negedge clk); byteValid = 1'b1; firstIn = 1'b1; byteIn = 8'h66;
    @(negedge clk); byteValid = 1'b0; firstIn = 1'b0;
    chk("R1 restart", int'(prefixDone), 0);

    // constrained random
    for (int t = 0; t < 400; t++) begin
      int np;
      logic [7:0] pool [11];
      pool = '{8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36, 8'h3E,
               8'h64, 8'h65, 8'h66, 8'h67};
      m  = 2'($urandom_range(0, 2));
      np = $urandom_range(0, 6);
      for (int i = 0; i < np; i++) begin
        if (m == 2'd2 && $urandom_range(0, 3) == 0)
          seq[i] = 8'h40 | 8'($urandom_range(0, 15));
        else
          seq[i] = pool[$urandom_range(0, 10)];
      end
      begin
        logic [7:0] op;
        op = 8'($urandom);
        while (isLegacyByte(op) || (m == 2'd2 && op[7:4] == 4'h4)) op = 8'($urandom);
        seq[np] = op;
      end
      seqLen = np + 1;
      runInstr(m);
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule